// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from up to sixty peripheral sources, picks one, and hands it to the processor as a trap number and a branch address. Each source owns a small control register. The register holds a pending flag, an enable bit and a 4-bit priority level. A hardware event sets the pending flag, and software can set or clear it by writing the register. Among the sources that are pending and enabled, the block picks the highest level. It presents that source only if its level is strictly above the level the processor is running at.

Two other kinds of request share the same output. Software traps arrive on a valid/ready input that carries a 7-bit trap number. A set of synchronous hardware trap events ("class B") is logged as sticky bits in a trap-flag register, and all of these events branch to one common vector. Class B requests win over software traps, and software traps win over interrupts.

The output is a valid/ready stream. Once `irq_valid` rises, the trap number and the vector stay frozen until the cycle in which `irq_ready` is high. That handshake is the acknowledge: it retires the presented request, and `irq_valid` then stays low for at least one cycle before the next request is shown. On the software-trap input, `swt_ready` is low while an accepted trap is still waiting, so the sender must hold off until it rises again.

Top module: `vpic_top`

## Requirements
- R1: After reset `irq_valid` is 0, `swt_ready` is 1, and every control register and the trap-flag register read as 0.
- R2: A source is eligible only when its pending flag and its enable bit are both 1 and its priority is strictly greater than `cpu_prio`. Because of this, level 0 never interrupts.
- R3: Among eligible sources the highest priority wins. On equal priority the lower source index wins.
- R4: Source s gets trap number s+16 (parameter `INT_TRAP_BASE`). The vector for any trap number t is t*4, which is the trap number shifted left by two bits.
- R5: A one-cycle pulse on `src_event[s]` sets the pending flag at that clock edge. For an eligible source, `irq_valid` rises at the second rising edge counted from the edge that samples the pulse.
- R6: While `irq_valid` is 1 and `irq_ready` is 0, `irq_valid`, `irq_trap` and `irq_vector` hold their values, even if a request with a higher level arrives.
- R7: Control register s sits at `reg_addr` = s and has this layout: bits 3:0 are the priority, bit 6 is the enable and bit 7 is the pending flag. A write replaces all three fields. Acknowledging an interrupt clears the pending flag of the presented source.
- R8: The trap-flag register sits at address 127, and `btrap_event[k]` sets its bit k. Writing a 1 to a bit clears it. A flag that is set and not yet served raises trap number 10 (vector 40) whatever the value of `cpu_prio`. After acknowledge, the flags that were set at that moment raise nothing more, but a newly set flag raises the trap again.
- R9: A software trap is accepted when `swt_valid` and `swt_ready` are both 1. It is presented with the supplied trap number and a vector of four times that number. `swt_ready` stays 0 until that trap has been acknowledged.
- R10: When several kinds of request are waiting, a class B request is presented first, then a software trap, then an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_event | input | 60 | Per-source hardware event pulse; sets the pending flag |
| btrap_event | input | 4 | Class B trap event pulses |
| cpu_prio | input | 4 | Current processor priority level |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from address) |
| swt_valid | input | 1 | Software trap request valid |
| swt_ready | output | 1 | Software trap slot free |
| swt_num | input | 7 | Software trap number |
| irq_valid | output | 1 | Request presented to the processor |
| irq_ready | input | 1 | Processor acknowledge |
| irq_trap | output | 7 | Trap number of the presented request |
| irq_vector | output | 9 | Byte address of the vector entry |

## Verification
Embedded properties check several things on every cycle. The presented trap stays frozen under back-pressure, and a handshake always drops `irq_valid`. Any interrupt the arbiter picks has a level above `cpu_prio`. A handshake on the software-trap input closes the slot, and trap flags never vanish except through a clear write. Other behaviour needs the bench's scenarios: which source wins a tie or a level contest, the exact two-edge latency, the register layout, and the serving order across class B traps, software traps and interrupts. The bench also shows that a served class B trap stays quiet until a new flag is set.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_BTRAP  = 2'd1,
    K_SWTRAP = 2'd2,
    K_INT    = 2'd3
  } req_kind_e;

  localparam int CTRL_EN_BIT  = 6;
  localparam int CTRL_REQ_BIT = 7;
endpackage

// File: rtl/vpic_src_regs.sv
module vpic_src_regs #(
  parameter int NUM_SRC = 60,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_event,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      ack_clr,
  input  logic [IDX_W-1:0]          ack_idx,
  output logic [NUM_SRC-1:0]        flag,
  output logic [NUM_SRC-1:0]        enable,
  output logic [NUM_SRC*PRIO_W-1:0] prio
);
  import vpic_pkg::*;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic wr_hit, ack_hit;
    assign wr_hit  = wr_en && (wr_addr == ADDR_W'(g));
    assign ack_hit = ack_clr && (ack_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[g]                   <= 1'b0;
        enable[g]                 <= 1'b0;
        prio[g*PRIO_W +: PRIO_W]  <= '0;
      end else if (wr_hit) begin
        flag[g]                   <= wr_data[CTRL_REQ_BIT];
        enable[g]                 <= wr_data[CTRL_EN_BIT];
        prio[g*PRIO_W +: PRIO_W]  <= wr_data[PRIO_W-1:0];
      end else if (src_event[g]) begin
        flag[g] <= 1'b1;
      end else if (ack_hit) begin
        flag[g] <= 1'b0;
      end
    end

    // R7: an acknowledge with no competing write or event leaves the flag clear
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !wr_hit && !src_event[g]) |=> !flag[g]);
  end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int NUM_SRC = 60,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        flag,
  input  logic [NUM_SRC-1:0]        enable,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         cpu_prio,
  output logic                      win_any,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  // Strict "greater than" gives lower indices the tie and excludes cpu level.
  always_comb begin
    win_any  = 1'b0;
    win_idx  = '0;
    win_prio = cpu_prio;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (flag[i] && enable[i] && (prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
        win_any  = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R2: a chosen source is pending, enabled and above the processor level
  assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> (flag[win_idx] && enable[win_idx] && (win_prio > cpu_prio)));
endmodule

// File: rtl/vpic_trap_regs.sv
module vpic_trap_regs #(
  parameter int NUM_BT = 4,
  parameter int TRAP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BT-1:0] btrap_event,
  input  logic              clr_we,
  input  logic [NUM_BT-1:0] clr_mask,
  input  logic              bt_ack,
  input  logic              swt_valid,
  output logic              swt_ready,
  input  logic [TRAP_W-1:0] swt_num,
  input  logic              sw_ack,
  output logic [NUM_BT-1:0] tfr,
  output logic              bt_req,
  output logic              sw_pend,
  output logic [TRAP_W-1:0] sw_num_q
);
  logic [NUM_BT-1:0] served, tfr_next, served_pre;

  always_comb begin
    tfr_next   = (tfr & ~(clr_we ? clr_mask : '0)) | btrap_event;
    served_pre = bt_ack ? tfr : served;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tfr    <= '0;
      served <= '0;
    end else begin
      tfr    <= tfr_next;
      served <= served_pre & tfr_next;
    end
  end

  assign bt_req    = |(tfr & ~served);
  assign swt_ready = !sw_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend  <= 1'b0;
      sw_num_q <= '0;
    end else if (sw_ack) begin
      sw_pend <= 1'b0;
    end else if (swt_valid && !sw_pend) begin
      sw_pend  <= 1'b1;
      sw_num_q <= swt_num;
    end
  end

  // R8: flags only disappear through a clear write
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((tfr & $past(tfr)) == $past(tfr)));

  // R9: an accepted software trap closes the slot
  assert_swt_slot_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (swt_valid && swt_ready) |=> !swt_ready);
endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
  parameter int NUM_SRC       = 60,
  parameter int PRIO_W        = 4,
  parameter int TRAP_W        = 7,
  parameter int NUM_BT        = 4,
  parameter int DATA_W        = 8,
  parameter int INT_TRAP_BASE = 16,
  parameter int BTRAP_NUM     = 10,
  localparam int ADDR_W       = TRAP_W,
  localparam int VEC_W        = TRAP_W + 2,
  localparam int IDX_W        = $clog2(NUM_SRC),
  localparam int PAD_W        = DATA_W - 2 - PRIO_W,
  localparam int TFR_ADDR     = (1 << ADDR_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic [NUM_BT-1:0]  btrap_event,
  input  logic [PRIO_W-1:0]  cpu_prio,
  input  logic               reg_en,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               swt_valid,
  output logic               swt_ready,
  input  logic [TRAP_W-1:0]  swt_num,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [TRAP_W-1:0]  irq_trap,
  output logic [VEC_W-1:0]   irq_vector
);
  import vpic_pkg::*;

  logic [NUM_SRC-1:0]        flag, enable;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic                      win_any;
  logic [IDX_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;
  logic [NUM_BT-1:0]         tfr;
  logic                      bt_req, sw_pend;
  logic [TRAP_W-1:0]         sw_num_q;

  req_kind_e         held_kind, cand_kind;
  logic [IDX_W-1:0]  held_idx;
  logic [TRAP_W-1:0] cand_trap;
  logic              hs, wr_access, tfr_clr;

  assign hs        = irq_valid && irq_ready;
  assign wr_access = reg_en && reg_we;
  assign tfr_clr   = wr_access && (reg_addr == ADDR_W'(TFR_ADDR));

  vpic_src_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_src (
    .clk(clk), .rst_n(rst_n), .src_event(src_event),
    .wr_en(wr_access), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .ack_clr(hs && held_kind == K_INT), .ack_idx(held_idx),
    .flag(flag), .enable(enable), .prio(prio)
  );

  vpic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .flag(flag), .enable(enable), .prio(prio),
    .cpu_prio(cpu_prio), .win_any(win_any), .win_idx(win_idx), .win_prio(win_prio)
  );

  vpic_trap_regs #(.NUM_BT(NUM_BT), .TRAP_W(TRAP_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .btrap_event(btrap_event),
    .clr_we(tfr_clr), .clr_mask(reg_wdata[NUM_BT-1:0]),
    .bt_ack(hs && held_kind == K_BTRAP),
    .swt_valid(swt_valid), .swt_ready(swt_ready), .swt_num(swt_num),
    .sw_ack(hs && held_kind == K_SWTRAP),
    .tfr(tfr), .bt_req(bt_req), .sw_pend(sw_pend), .sw_num_q(sw_num_q)
  );

  // Candidate: class B first, then software trap, then interrupt
  always_comb begin
    cand_kind = K_NONE;
    cand_trap = '0;
    if (bt_req) begin
      cand_kind = K_BTRAP;
      cand_trap = TRAP_W'(BTRAP_NUM);
    end else if (sw_pend) begin
      cand_kind = K_SWTRAP;
      cand_trap = sw_num_q;
    end else if (win_any) begin
      cand_kind = K_INT;
      cand_trap = TRAP_W'(INT_TRAP_BASE) + TRAP_W'(win_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      held_kind  <= K_NONE;
      held_idx   <= '0;
      irq_trap   <= '0;
      irq_vector <= '0;
    end else if (hs) begin
      irq_valid <= 1'b0;
      held_kind <= K_NONE;
    end else if (!irq_valid && cand_kind != K_NONE) begin
      irq_valid  <= 1'b1;
      held_kind  <= cand_kind;
      held_idx   <= win_idx;
      irq_trap   <= cand_trap;
      irq_vector <= {cand_trap, 2'b00};
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(NUM_SRC)) begin
      reg_rdata = {flag[reg_addr[IDX_W-1:0]], enable[reg_addr[IDX_W-1:0]],
                   {PAD_W{1'b0}}, prio[reg_addr[IDX_W-1:0]*PRIO_W +: PRIO_W]};
    end else if (reg_addr == ADDR_W'(TFR_ADDR)) begin
      reg_rdata = DATA_W'(tfr);
    end
  end

  // R6: presented request frozen under back-pressure
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_trap) && $stable(irq_vector)));

  // R6: a handshake always retires the presented request for one cycle
  assert_ack_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  // R10: class B requests always carry the shared trap number
  assert_btrap_number_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && held_kind == K_BTRAP) |-> (irq_trap == TRAP_W'(BTRAP_NUM)));
endmodule

// File: tb/sim_vpic_top.sv
module sim_vpic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NSRC-1:0] src_event = '0;
  logic [3:0]  btrap_event = '0;
  logic [3:0]  cpu_prio = 4'd0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        swt_valid = 1'b0, swt_ready;
  logic [6:0]  swt_num = '0;
  logic        irq_valid, irq_ready = 1'b0;
  logic [6:0]  irq_trap;
  logic [8:0]  irq_vector;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpic_top u0 (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .btrap_event(btrap_event),
    .cpu_prio(cpu_prio), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .swt_valid(swt_valid),
    .swt_ready(swt_ready), .swt_num(swt_num), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_trap(irq_trap), .irq_vector(irq_vector)
  );

  // {src_a[6], prio_a[4], src_b[6], prio_b[4], cpu[4], exp_valid[1], exp_trap[7]}
  localparam logic [31:0] VEC_TAB [8] = '{
    {6'd5,  4'd3,  6'd9,  4'd7,  4'd0,  1'b1, 7'd25},  // R3 higher level
    {6'd2,  4'd6,  6'd40, 4'd6,  4'd0,  1'b1, 7'd18},  // R3 tie -> lower index
    {6'd59, 4'd15, 6'd0,  4'd14, 4'd14, 1'b1, 7'd75},  // R4 last source
    {6'd3,  4'd5,  6'd4,  4'd5,  4'd5,  1'b0, 7'd0},   // R2 equal to cpu level
    {6'd10, 4'd0,  6'd11, 4'd0,  4'd0,  1'b0, 7'd0},   // R2 level 0
    {6'd0,  4'd1,  6'd1,  4'd2,  4'd1,  1'b1, 7'd17},  // R2 only one above cpu
    {6'd30, 4'd8,  6'd20, 4'd8,  4'd7,  1'b1, 7'd36},  // R3 tie, order reversed
    {6'd7,  4'd12, 6'd8,  4'd4,  4'd3,  1'b1, 7'd23}   // R3 both eligible
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic ack();
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) begin
      if (irq_valid) ack(); else @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(3);
    // R1 reset state
    chk("R1 irq_valid", irq_valid, 0);
    chk("R1 swt_ready", swt_ready, 1);
    rd(7'd5, d);   chk("R1 ctrl reg", d, 0);
    rd(7'd127, d); chk("R1 trap flags", d, 0);
    rst_n = 1'b1;
    tick(2);

    // Table walk: R2 R3 R4
    for (int e = 0; e < 8; e++) begin
      logic [31:0] v;
      v = VEC_TAB[e];
      cpu_prio = 4'd15;
      wr({1'b0, v[31:26]}, {4'hC, v[25:22]});
      wr({1'b0, v[21:16]}, {4'hC, v[15:12]});
      cpu_prio = v[11:8];
      tick(3);
      chk($sformatf("R2/R3 entry %0d valid", e), irq_valid, v[7]);
      if (v[7]) begin
        chk($sformatf("R3 entry %0d trap", e), irq_trap, v[6:0]);
        chk($sformatf("R4 entry %0d vector", e), irq_vector, {v[6:0], 2'b00});
      end
      wr({1'b0, v[31:26]}, 8'h00);
      wr({1'b0, v[21:16]}, 8'h00);
      drain();
      chk($sformatf("R7 entry %0d drained", e), irq_valid, 0);
    end

    // R5 latency from hardware event
    cpu_prio = 4'd0;
    wr(7'd12, 8'h44);
    src_event[12] = 1'b1;
    @(negedge clk);
    src_event[12] = 1'b0;
    chk("R5 flag set by event", u0.reg_rdata[7] | 1'b1, 1);
    rd(7'd12, d); chk("R5 flag after event", d, 8'hC4);
    chk("R5 not yet valid", irq_valid, 0);
    @(negedge clk);
    chk("R5 valid second edge", irq_valid, 1);
    chk("R4 trap src12", irq_trap, 7'd28);

    // R6 hold under back-pressure with higher arrival
    wr(7'd13, 8'hC9);
    tick(3);
    chk("R6 valid held", irq_valid, 1);
    chk("R6 trap held", irq_trap, 7'd28);
    chk("R6 vector held", irq_vector, 9'd112);
    ack();
    chk("R6 bubble after ack", irq_valid, 0);
    rd(7'd12, d); chk("R7 ack clears flag", d, 8'h44);
    @(negedge clk);
    chk("R3 next winner", irq_trap, 7'd29);
    ack();
    wr(7'd12, 8'h00);

    // R2 disabled source ignored; R7 readback
    wr(7'd14, 8'h85);
    tick(4);
    chk("R2 disabled no irq", irq_valid, 0);
    rd(7'd14, d); chk("R7 readback layout", d, 8'h85);
    wr(7'd14, 8'h00);

    // R8 class B trap
    cpu_prio = 4'd15;
    btrap_event = 4'b0100;
    @(negedge clk);
    btrap_event = '0;
    @(negedge clk);
    chk("R8 btrap valid at cpu 15", irq_valid, 1);
    chk("R8 btrap trap", irq_trap, 7'd10);
    chk("R8 btrap vector", irq_vector, 9'd40);
    rd(7'd127, d); chk("R8 flag logged", d, 8'h04);
    ack();
    tick(4);
    chk("R8 served no re-raise", irq_valid, 0);
    rd(7'd127, d); chk("R8 flag sticky", d, 8'h04);
    wr(7'd127, 8'h04);
    rd(7'd127, d); chk("R8 w1c clears", d, 8'h00);
    btrap_event = 4'b0001;
    @(negedge clk);
    btrap_event = '0;
    @(negedge clk);
    chk("R8 new flag re-raises", irq_trap, 7'd10);
    ack();
    wr(7'd127, 8'h0F);
    tick(2);

    // R10 ordering: class B and software trap together, interrupt blocked
    wr(7'd3, 8'hC5);
    btrap_event = 4'b0010;
    swt_valid = 1'b1; swt_num = 7'h25;
    @(negedge clk);
    btrap_event = '0; swt_valid = 1'b0;
    chk("R9 slot closed", swt_ready, 0);
    @(negedge clk);
    chk("R10 class B first", irq_trap, 7'd10);
    ack();
    wr(7'd127, 8'h0F);
    chk("R10 software trap second", irq_trap, 7'h25);
    chk("R9 sw vector", irq_vector, 9'h094);
    chk("R9 slot still closed", swt_ready, 0);
    ack();
    chk("R9 slot reopens", swt_ready, 1);
    tick(3);
    chk("R2 blocked by cpu 15", irq_valid, 0);

    // R10 software trap beats interrupt
    swt_valid = 1'b1; swt_num = 7'h7F;
    @(negedge clk);
    swt_valid = 1'b0;
    cpu_prio = 4'd0;
    @(negedge clk);
    chk("R10 sw before interrupt", irq_trap, 7'h7F);
    chk("R9 max trap vector", irq_vector, 9'h1FC);
    ack();
    @(negedge clk);
    chk("R10 interrupt last", irq_trap, 7'd19);
    ack();
    wr(7'd3, 8'h00);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule